// File: doc/BRIEF.md
# Port Clock and Frame-Sync Generator

This block turns a fast oscillator into a port bit clock and a frame-sync pulse for a bank of serial ports. A 3-bit mode code picks a clock divide ratio. Each ratio that carries framing comes with a frame length, counted in output clocks. The sync is a single pulse, one output clock wide. It rises together with the output clock on the clock that wraps the frame counter. Two copies of the generator run side by side. One is clocked from a transmit oscillator and one from a receive oscillator, so the two directions can be asynchronous to each other and share no state.

Every port receives the same clock and sync. The exception is the two lowest ports: a control input can switch them to a faster fixed-ratio clock with no framing. A second control holds every sync low while the clocks keep running. An output enable floats all clock, sync and data outputs. The block also loops data in a ring: the transmit data of each port is driven onto the receive data output of the next port, and the last port feeds port 0.

The mode, force and fast controls are treated as slow static settings. They are re-timed into each oscillator domain. A change of mode restarts the divider and the frame counter of that domain.

Top module: `port_clk_sync_gen`

## Requirements
- R1: On ports 2 and up, the output clock period in oscillator cycles is 6, 8, 16, 32 or 42 for mode codes 000, 001, 010, 011 and 100 respectively. The clock is high for the second half of each period.
- R2: With mode code 000, no sync output ever goes high.
- R3: The sync repeats every 1024, 512, 256 or 193 output clocks for mode codes 001, 010, 011 and 100 respectively.
- R4: A sync pulse rises in the same oscillator cycle as a rising edge of the output clock. It stays high for exactly one output clock period.
- R5: With mode codes 101, 110 or 111, every clock and sync output is held low.
- R6: While sync_force is 1, every sync output stays low and the clocks keep their normal period.
- R7: While fast_lo is 1, ports 0 and 1 get a clock of the oscillator divided by FAST_DIV (2 by default), and their syncs stay low. Ports 2 and up are unaffected. While fast_lo is 0, ports 0 and 1 behave like the others.
- R8: While out_en is 0, every clock, sync and receive-data output is high impedance.
- R9: While out_en is 1, rx_data bit (p+1) mod N_PORTS equals tx_data bit p for every port p.
- R10: The receive-side clock is divided from rx_osc_clk alone, and its period counted in receive oscillator cycles follows R1.
- R11: While rst_n is low, all clock and sync outputs are low.
- R12: A change of mode code clears the divider and the frame counter. Counting from the restart, the first sync of the new mode arrives on exactly the frame-length-th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_osc_clk | input | 1 | Transmit-side oscillator |
| rx_osc_clk | input | 1 | Receive-side oscillator |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| mode_sel | input | 3 | Divide/frame mode code |
| sync_force | input | 1 | 1 holds all syncs low |
| fast_lo | input | 1 | 1 gives ports 0 and 1 the fast clock |
| out_en | input | 1 | 0 floats all outputs |
| tx_data | input | N_PORTS | Transmit data per port, looped to the next port |
| tx_clk | output | N_PORTS | Transmit clock per port |
| tx_sync | output | N_PORTS | Transmit frame sync per port |
| rx_clk | output | N_PORTS | Receive clock per port |
| rx_sync | output | N_PORTS | Receive frame sync per port |
| rx_data | output | N_PORTS | Receive data per port, from the previous port |

## Verification
Every defined mode code is swept in turn. For each one the clock period, the count of clocks between sync pulses and the pulse width are measured arithmetically against the expected ratio and frame length. A mismatch in any single ratio or frame length is therefore isolated. Reserved codes, forced sync and the fast low-port clock are run while the other ports keep working, which separates per-port effects from global ones. A mode switch in the middle of a frame shows whether the frame counter truly restarts. All 16 data patterns are sent through the ring to expose any mis-rotated wiring, and the disabled state is read through pull-ups.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int MODE_W = 3;
  localparam int DIV_W  = 6;
  localparam int FRM_W  = 10;

  typedef struct packed {
    logic             valid;
    logic             chan;
    logic [DIV_W-1:0] div_last;
    logic [DIV_W-1:0] half;
    logic [FRM_W-1:0] frm_last;
  } cfg_t;

  function automatic cfg_t mk_cfg(input int div, input int frm, input logic chan);
    cfg_t c;
    c.valid    = 1'b1;
    c.chan     = chan;
    c.div_last = DIV_W'(div - 1);
    c.half     = DIV_W'(div / 2);
    c.frm_last = FRM_W'(frm - 1);
    return c;
  endfunction

  function automatic cfg_t decode_mode(input logic [MODE_W-1:0] m);
    cfg_t c;
    case (m)
      3'd0:    c = mk_cfg(6, 1, 1'b0);
      3'd1:    c = mk_cfg(8, 1024, 1'b1);
      3'd2:    c = mk_cfg(16, 512, 1'b1);
      3'd3:    c = mk_cfg(32, 256, 1'b1);
      3'd4:    c = mk_cfg(42, 193, 1'b1);
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_no = stg_q[1];
endmodule

// File: rtl/pcg_sync_vec.sv
module pcg_sync_vec #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pcg_dir_gen.sv
module pcg_dir_gen
  import pcg_pkg::*;
#(
  parameter int FAST_DIV = 2
) (
  input  logic              osc_clk,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              force_i,
  input  logic              fast_i,
  output logic              clk_main_o,
  output logic              sync_main_o,
  output logic              clk_lo_o,
  output logic              sync_lo_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              force_o,
  output logic              fast_o
);
  localparam int CTL_W = MODE_W + 2;
  localparam int FW    = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
  localparam int FHALF = FAST_DIV / 2;
  localparam int FLAST = FAST_DIV - 1;

  logic              rst_n;
  logic [CTL_W-1:0]  ctl_s;
  logic [MODE_W-1:0] mode_s;
  logic              force_s, fast_s;

  pcg_rst_sync u_rst (
    .clk_i  (osc_clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pcg_sync_vec #(.W(CTL_W)) u_ctl (
    .clk_i  (osc_clk),
    .rst_ni (rst_n),
    .d_i    ({mode_i, force_i, fast_i}),
    .q_o    (ctl_s)
  );

  assign mode_s  = ctl_s[CTL_W-1:2];
  assign force_s = ctl_s[1];
  assign fast_s  = ctl_s[0];

  // state
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic              clk_q, clk_n;
  logic [FRM_W-1:0]  frm_q, frm_n;
  logic              pulse_q, pulse_n;
  logic              sync_q, sync_n;
  logic [FW-1:0]     fcnt_q, fcnt_n;
  logic              lo_clk_q, lo_clk_n;
  logic              lo_sync_q, lo_sync_n;

  cfg_t cfg;
  logic mode_chg;
  logic rise;
  logic fast_clk_n;

  assign cfg      = decode_mode(mode_s);
  assign mode_chg = (mode_s != mode_q);

  // divider and frame counter next state
  always_comb begin
    mode_n  = mode_s;
    div_n   = '0;
    clk_n   = 1'b0;
    frm_n   = '0;
    pulse_n = 1'b0;
    rise    = 1'b0;
    if (!mode_chg && cfg.valid) begin
      div_n = (div_q == cfg.div_last) ? '0 : div_q + 1'b1;
      clk_n = (div_n >= cfg.half);
      rise  = (div_n == cfg.half);
      frm_n   = frm_q;
      pulse_n = pulse_q;
      if (rise) begin
        frm_n   = (frm_q == cfg.frm_last) ? '0 : frm_q + 1'b1;
        pulse_n = cfg.chan && (frm_n == '0);
      end
    end
    if (rise) sync_n = pulse_n & ~force_s;
    else      sync_n = sync_q & pulse_n & ~force_s;
  end

  // fast clock and low-port selection next state
  always_comb begin
    fcnt_n     = (fcnt_q == FW'(FLAST)) ? '0 : fcnt_q + 1'b1;
    fast_clk_n = (fcnt_n >= FW'(FHALF));
    lo_clk_n   = fast_s ? fast_clk_n : clk_n;
    lo_sync_n  = fast_s ? 1'b0 : sync_n;
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      div_q     <= '0;
      clk_q     <= 1'b0;
      frm_q     <= '0;
      pulse_q   <= 1'b0;
      sync_q    <= 1'b0;
      fcnt_q    <= '0;
      lo_clk_q  <= 1'b0;
      lo_sync_q <= 1'b0;
    end else begin
      mode_q    <= mode_n;
      div_q     <= div_n;
      clk_q     <= clk_n;
      frm_q     <= frm_n;
      pulse_q   <= pulse_n;
      sync_q    <= sync_n;
      fcnt_q    <= fcnt_n;
      lo_clk_q  <= lo_clk_n;
      lo_sync_q <= lo_sync_n;
    end
  end

  assign clk_main_o  = clk_q;
  assign sync_main_o = sync_q;
  assign clk_lo_o    = lo_clk_q;
  assign sync_lo_o   = lo_sync_q;
  assign mode_o      = mode_q;
  assign force_o     = force_s;
  assign fast_o      = fast_s;
endmodule

// File: rtl/port_clk_sync_gen.sv
module port_clk_sync_gen
  import pcg_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int FAST_DIV = 2
) (
  input  wire                 tx_osc_clk,
  input  wire                 rx_osc_clk,
  input  wire                 rst_n,
  input  wire [MODE_W-1:0]    mode_sel,
  input  wire                 sync_force,
  input  wire                 fast_lo,
  input  wire                 out_en,
  input  wire [N_PORTS-1:0]   tx_data,
  output wire [N_PORTS-1:0]   tx_clk,
  output wire [N_PORTS-1:0]   tx_sync,
  output wire [N_PORTS-1:0]   rx_clk,
  output wire [N_PORTS-1:0]   rx_sync,
  output wire [N_PORTS-1:0]   rx_data
);
  localparam int N_LO = 2;

  logic              tx_clk_m, tx_sync_m, tx_clk_l, tx_sync_l;
  logic              rx_clk_m, rx_sync_m, rx_clk_l, rx_sync_l;
  logic [MODE_W-1:0] tx_mode_q, rx_mode_q;
  logic              tx_force_s, rx_force_s, tx_fast_s, rx_fast_s;

  pcg_dir_gen #(.FAST_DIV(FAST_DIV)) u_tx (
    .osc_clk     (tx_osc_clk),
    .rst_ni      (rst_n),
    .mode_i      (mode_sel),
    .force_i     (sync_force),
    .fast_i      (fast_lo),
    .clk_main_o  (tx_clk_m),
    .sync_main_o (tx_sync_m),
    .clk_lo_o    (tx_clk_l),
    .sync_lo_o   (tx_sync_l),
    .mode_o      (tx_mode_q),
    .force_o     (tx_force_s),
    .fast_o      (tx_fast_s)
  );

  pcg_dir_gen #(.FAST_DIV(FAST_DIV)) u_rx (
    .osc_clk     (rx_osc_clk),
    .rst_ni      (rst_n),
    .mode_i      (mode_sel),
    .force_i     (sync_force),
    .fast_i      (fast_lo),
    .clk_main_o  (rx_clk_m),
    .sync_main_o (rx_sync_m),
    .clk_lo_o    (rx_clk_l),
    .sync_lo_o   (rx_sync_l),
    .mode_o      (rx_mode_q),
    .force_o     (rx_force_s),
    .fast_o      (rx_fast_s)
  );

  logic [N_PORTS-1:0] tx_clk_d, tx_sync_d, rx_clk_d, rx_sync_d, rx_data_d;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    if (p < N_LO) begin : g_lo
      assign tx_clk_d[p]  = tx_clk_l;
      assign tx_sync_d[p] = tx_sync_l;
      assign rx_clk_d[p]  = rx_clk_l;
      assign rx_sync_d[p] = rx_sync_l;
    end else begin : g_hi
      assign tx_clk_d[p]  = tx_clk_m;
      assign tx_sync_d[p] = tx_sync_m;
      assign rx_clk_d[p]  = rx_clk_m;
      assign rx_sync_d[p] = rx_sync_m;
    end
    assign rx_data_d[(p + 1) % N_PORTS] = tx_data[p];
  end

  assign tx_clk  = out_en ? tx_clk_d  : {N_PORTS{1'bz}};
  assign tx_sync = out_en ? tx_sync_d : {N_PORTS{1'bz}};
  assign rx_clk  = out_en ? rx_clk_d  : {N_PORTS{1'bz}};
  assign rx_sync = out_en ? rx_sync_d : {N_PORTS{1'bz}};
  assign rx_data = out_en ? rx_data_d : {N_PORTS{1'bz}};
endmodule

// File: rtl/port_clk_sync_gen_chk.sv
module port_clk_sync_gen_chk (
  input logic       tx_osc,
  input logic       rx_osc,
  input logic       rst_n,
  input logic       tx_clk_m,
  input logic       tx_sync_m,
  input logic       tx_sync_l,
  input logic [2:0] tx_mode_q,
  input logic       tx_force_s,
  input logic       tx_fast_s,
  input logic       rx_clk_m,
  input logic       rx_sync_m,
  input logic [2:0] rx_mode_q
);
  assert_reserved_low_R5: assert property (@(posedge tx_osc) disable iff (!rst_n)
    (tx_mode_q inside {3'd5, 3'd6, 3'd7}) |-> (!tx_clk_m && !tx_sync_m));

  assert_rx_reserved_low_R5: assert property (@(posedge rx_osc) disable iff (!rst_n)
    (rx_mode_q inside {3'd5, 3'd6, 3'd7}) |-> (!rx_clk_m && !rx_sync_m));

  assert_unch_no_sync_R2: assert property (@(posedge tx_osc) disable iff (!rst_n)
    (tx_mode_q == 3'd0) |-> !tx_sync_m);

  assert_sync_on_edge_R4: assert property (@(posedge tx_osc) disable iff (!rst_n)
    $rose(tx_sync_m) |-> $rose(tx_clk_m));

  assert_restart_R12: assert property (@(posedge tx_osc) disable iff (!rst_n)
    (tx_mode_q != $past(tx_mode_q)) |-> (!tx_clk_m && !tx_sync_m));

  assert_force_low_R6: assert property (@(posedge tx_osc) disable iff (!rst_n)
    tx_force_s |=> !tx_sync_m);

  assert_fast_no_sync_R7: assert property (@(posedge tx_osc) disable iff (!rst_n)
    tx_fast_s |=> !tx_sync_l);
endmodule

bind port_clk_sync_gen port_clk_sync_gen_chk u_chk (
  .tx_osc     (tx_osc_clk),
  .rx_osc     (rx_osc_clk),
  .rst_n      (rst_n),
  .tx_clk_m   (tx_clk_m),
  .tx_sync_m  (tx_sync_m),
  .tx_sync_l  (tx_sync_l),
  .tx_mode_q  (tx_mode_q),
  .tx_force_s (tx_force_s),
  .tx_fast_s  (tx_fast_s),
  .rx_clk_m   (rx_clk_m),
  .rx_sync_m  (rx_sync_m),
  .rx_mode_q  (rx_mode_q)
);

// File: tb/port_clk_sync_gen_tb_top.sv
module port_clk_sync_gen_tb_top;
  localparam int N = 4;

  logic tx_osc = 1'b0;
  logic rx_osc = 1'b0;
  always #2 tx_osc = ~tx_osc;
  always #3 rx_osc = ~rx_osc;

  logic         rst_n;
  logic [2:0]   mode_sel;
  logic         sync_force, fast_lo, out_en;
  logic [N-1:0] tx_data;
  wire  [N-1:0] tx_clk_w, tx_sync_w, rx_clk_w, rx_sync_w, rx_data_w;

  for (genvar i = 0; i < N; i++) begin : g_pu
    pullup pu_a (tx_clk_w[i]);
    pullup pu_b (tx_sync_w[i]);
    pullup pu_c (rx_clk_w[i]);
    pullup pu_d (rx_sync_w[i]);
    pullup pu_e (rx_data_w[i]);
  end

  port_clk_sync_gen #(.N_PORTS(N), .FAST_DIV(2)) dut_i (
    .tx_osc_clk (tx_osc),
    .rx_osc_clk (rx_osc),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .sync_force (sync_force),
    .fast_lo    (fast_lo),
    .out_en     (out_en),
    .tx_data    (tx_data),
    .tx_clk     (tx_clk_w),
    .tx_sync    (tx_sync_w),
    .rx_clk     (rx_clk_w),
    .rx_sync    (rx_sync_w),
    .rx_data    (rx_data_w)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // selectors: 0 tx clk port2, 1 tx clk port0, 2 rx clk port2,
  //            3 tx sync port2, 4 tx sync port0, 5 rx sync port2
  function automatic logic sig(input int sel);
    case (sel)
      0: return tx_clk_w[2];
      1: return tx_clk_w[0];
      2: return rx_clk_w[2];
      3: return tx_sync_w[2];
      4: return tx_sync_w[0];
      default: return rx_sync_w[2];
    endcase
  endfunction

  task automatic step(input int sel);
    if (sel == 2 || sel == 5) @(negedge rx_osc);
    else @(negedge tx_osc);
  endtask

  task automatic wait_tx(input int n);
    repeat (n) @(negedge tx_osc);
  endtask

  task automatic clk_period(input int sel, output int per);
    logic prev;
    int   lim;
    per  = -1;
    prev = sig(sel);
    lim  = 0;
    while (lim < 2000) begin
      step(sel);
      lim++;
      if (!prev && sig(sel)) break;
      prev = sig(sel);
    end
    if (lim >= 2000) return;
    per  = 0;
    prev = 1'b1;
    while (per < 2000) begin
      step(sel);
      per++;
      if (!prev && sig(sel)) break;
      prev = sig(sel);
    end
  endtask

  task automatic count_high(input int sel, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step(sel);
      if (sig(sel) !== 1'b0) hits++;
    end
  endtask

  // clock rises between consecutive sync rises, and sync width in osc cycles
  task automatic sync_measure(output int rises, output int width);
    logic ps, pc;
    int   lim;
    logic in_pulse;
    rises = -1;
    width = -1;
    ps = sig(3);
    lim = 0;
    while (lim < 20000) begin
      step(0);
      lim++;
      if (!ps && sig(3)) break;
      ps = sig(3);
    end
    if (lim >= 20000) return;
    rises = 0;
    width = 1;
    in_pulse = 1'b1;
    ps = 1'b1;
    pc = sig(0);
    lim = 0;
    while (lim < 60000) begin
      step(0);
      lim++;
      if (!pc && sig(0)) rises++;
      if (!ps && sig(3)) break;
      if (in_pulse && sig(3)) width++;
      else in_pulse = 1'b0;
      ps = sig(3);
      pc = sig(0);
    end
    if (lim >= 60000) rises = -1;
  endtask

  function automatic int exp_div(input int m);
    case (m)
      0: return 6;
      1: return 8;
      2: return 16;
      3: return 32;
      default: return 42;
    endcase
  endfunction

  function automatic int exp_frm(input int m);
    case (m)
      1: return 1024;
      2: return 512;
      3: return 256;
      default: return 193;
    endcase
  endfunction

  initial begin
    int per, rises, width, hits;
    logic prev;
    rst_n = 1'b0; mode_sel = 3'd3; sync_force = 1'b0; fast_lo = 1'b0;
    out_en = 1'b1; tx_data = '0;
    wait_tx(6);
    // R11: reset state
    check((tx_clk_w | tx_sync_w) === 4'b0000, "R11 tx outputs in reset", int'(tx_clk_w | tx_sync_w), 0);
    check((rx_clk_w | rx_sync_w) === 4'b0000, "R11 rx outputs in reset", int'(rx_clk_w | rx_sync_w), 0);
    rst_n = 1'b1;
    wait_tx(4);

    // R1, R3, R4: sweep framed modes
    for (int m = 1; m <= 4; m++) begin
      mode_sel = 3'(m);
      wait_tx(6);
      clk_period(0, per);
      check(per == exp_div(m), $sformatf("R1 period mode %0d", m), per, exp_div(m));
      sync_measure(rises, width);
      check(rises == exp_frm(m), $sformatf("R3 frame mode %0d", m), rises, exp_frm(m));
      check(width == exp_div(m), $sformatf("R4 sync width mode %0d", m), width, exp_div(m));
    end

    // R1 and R2: unchannelized
    mode_sel = 3'd0;
    wait_tx(6);
    clk_period(0, per);
    check(per == 6, "R1 period mode 0", per, 6);
    count_high(3, 2000, hits);
    check(hits == 0, "R2 no sync in mode 0", hits, 0);

    // R10: receive side on its own oscillator
    mode_sel = 3'd2;
    wait_tx(10);
    clk_period(2, per);
    check(per == 16, "R10 rx period mode 2", per, 16);

    // R12: restart mid-frame
    mode_sel = 3'd3;
    wait_tx(3000);
    mode_sel = 3'd1;
    wait_tx(4);
    rises = 0;
    prev = sig(0);
    begin
      logic ps;
      int lim;
      ps = sig(3);
      lim = 0;
      while (lim < 20000) begin
        step(0);
        lim++;
        if (!prev && sig(0)) rises++;
        if (!ps && sig(3)) break;
        ps = sig(3);
        prev = sig(0);
      end
    end
    check(rises == 1024, "R12 first sync after restart", rises, 1024);

    // R6: forced sync
    mode_sel = 3'd3;
    sync_force = 1'b1;
    wait_tx(6);
    count_high(3, 8300, hits);
    check(hits == 0, "R6 sync held low", hits, 0);
    clk_period(0, per);
    check(per == 32, "R6 clock still runs", per, 32);
    sync_force = 1'b0;
    wait_tx(6);

    // R7: fast clock on low ports
    fast_lo = 1'b1;
    wait_tx(6);
    clk_period(1, per);
    check(per == 2, "R7 port0 fast period", per, 2);
    clk_period(0, per);
    check(per == 32, "R7 port2 unaffected", per, 32);
    count_high(4, 8300, hits);
    check(hits == 0, "R7 port0 sync low", hits, 0);
    fast_lo = 1'b0;
    wait_tx(6);
    clk_period(1, per);
    check(per == 32, "R7 port0 back to normal", per, 32);

    // R8: outputs float (pull-ups read 1)
    out_en = 1'b0;
    tx_data = '0;
    count_high(0, 64, hits);
    check(hits == 64, "R8 tx clk floating", hits, 64);
    #1;
    check({tx_clk_w, tx_sync_w, rx_clk_w, rx_sync_w, rx_data_w} === {5*N{1'b1}},
          "R8 all outputs floating",
          int'({tx_clk_w, tx_sync_w, rx_clk_w, rx_sync_w, rx_data_w}), (1 << (5*N)) - 1);
    out_en = 1'b1;

    // R5: reserved codes
    for (int m = 5; m <= 7; m++) begin
      mode_sel = 3'(m);
      wait_tx(8);
      count_high(0, 300, hits);
      check(hits == 0, $sformatf("R5 clk low mode %0d", m), hits, 0);
      count_high(3, 300, hits);
      check(hits == 0, $sformatf("R5 sync low mode %0d", m), hits, 0);
      count_high(2, 300, hits);
      check(hits == 0, $sformatf("R5 rx clk low mode %0d", m), hits, 0);
    end

    // R9: data ring, all patterns
    for (int v = 0; v < 16; v++) begin
      logic [N-1:0] exp_v;
      tx_data = 4'(v);
      #1;
      for (int p = 0; p < N; p++) exp_v[(p + 1) % N] = tx_data[p];
      check(rx_data_w === exp_v, "R9 ring data", int'(rx_data_w), int'(exp_v));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge tx_osc);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule